// File: doc/BRIEF.md
# PCI Bus Central Arbiter with Bus Parking

This block arbitrates a shared 32-bit PCI-style bus among three masters. One master sits inside the same device, and two sit outside it. Each outside master has an active-low request and grant pair. When nobody asks for the bus, the block hands it to the internal master (bus parking). That master then keeps the address/data, command/byte-enable and parity lines at valid levels, both while the bus is idle and while reset is held. Ownership rotates round-robin. A grant is taken away only at a safe point, and every hand-over between two masters passes through one cycle with no grant.

Two strap pins are captured while the reset input is low. The value present at reset release stays in force until the next reset. The straps turn on the arbiter and the central functions independently. With the arbiter off, the external grants stay inactive, and the internal master's request and grant are routed through a port to an arbiter elsewhere. With the central functions on, the block drives the bus reset line and records any system-error pulse in a sticky flag.

Top module: `pbus_central_arb`

## Requirements
- R1: `strap_cfg` is captured at every clock edge while `rst_in_n` is low, where bit 0 enables the arbiter and bit 1 enables the central functions. Changes on `strap_cfg` after `rst_in_n` goes high have no effect until the next reset.
- R2: While `rst_in_n` is low with the arbiter strap set, `int_gnt` is 1, `ext_gnt_n` is all ones and `park_drive` is 1.
- R3: With the arbiter enabled, at most one grant is active at a time. Master index 0 is the internal master (`int_gnt`, active high), index 1 is `ext_gnt_n[0]` and index 2 is `ext_gnt_n[1]` (both active low).
- R4: Grants are registered and change only at a clock edge. Between two different owners there is exactly one edge with no grant, and a cycle with no grant is always followed by a granted cycle.
- R5: At a no-grant edge with requests pending, the winner is the first requesting master after the last master granted through a request, searched in the order 0, 1, 2, 0. After reset the last granted master is 0.
- R6: An owner that keeps requesting while the bus is busy (`bus_frame_n` or `bus_irdy_n` low) keeps its grant. The grant is removed when another master requests and either the bus is idle or the owner has stopped requesting, or when an external owner stops requesting.
- R7: A no-grant edge with no requests parks the bus: `int_gnt` is asserted at that edge. `park_drive` is 1 whenever the internal master holds the grant and `int_req` is 0.
- R8: With the arbiter strap clear, `ext_gnt_n` is all ones, `int_gnt` equals the inverse of `xarb_gnt_n`, `xarb_req_n` equals the inverse of `int_req`, and `park_drive` is 0. With the strap set, `xarb_req_n` is 1.
- R9: `bus_rst_o_n` is 0 while `rst_in_n` is low and becomes 1 at the first clock edge after release. `bus_rst_oe` equals the captured central-function strap.
- R10: With the central strap set, `sys_err_n` low at a clock edge sets `err_flag` at that edge, and only a reset clears it. With the central strap clear, `sys_err_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_in_n | input | 1 | Active-low reset; straps captured while low |
| strap_cfg | input | 2 | Bit 0 arbiter enable, bit 1 central-function enable |
| int_req | input | 1 | Internal master bus request, active high |
| int_gnt | output | 1 | Internal master bus grant, active high |
| park_drive | output | 1 | Internal master must drive address/data, command and parity to valid levels |
| xarb_req_n | output | 1 | Internal request to an outside arbiter when this arbiter is off, active low |
| xarb_gnt_n | input | 1 | Grant from an outside arbiter, active low |
| ext_req_n | input | 2 | External master requests, active low |
| ext_gnt_n | output | 2 | External master grants, active low |
| bus_frame_n | input | 1 | Bus frame signal, active low |
| bus_irdy_n | input | 1 | Bus initiator-ready signal, active low |
| bus_rst_o_n | output | 1 | Bus reset output, active low |
| bus_rst_oe | output | 1 | Output enable for the bus reset line |
| sys_err_n | input | 1 | System-error input, active low |
| err_flag | output | 1 | Sticky system-error flag |

## Verification
The grant register and the round-robin pointer are state that the ports reveal directly. A corrupted grant shows at `int_gnt`/`ext_gnt_n` on the same edge. A corrupted pointer shows at the next award, as a wrong winner, which a sweep of overlapping requests exposes within three awards. A strap register that keeps sampling after reset shows as a change of arbiter mode in the first cycle after the pins move. A dropped sticky bit shows at `err_flag` one edge after the pulse.

// File: rtl/pbarb_pkg.sv
`timescale 1ns/1ps
package pbarb_pkg;
  localparam int NUM_EXT  = 2;
  localparam int NM       = NUM_EXT + 1;
  localparam int IDXW     = $clog2(NM);
  localparam int STRAP_W  = 2;
  localparam int STRAP_ARB = 0;
  localparam int STRAP_CEN = 1;

  typedef logic [NM-1:0]   mvec_t;
  typedef logic [IDXW-1:0] midx_t;

  localparam midx_t IDX_INT = '0;

  // one-hot vector for a master index
  function automatic mvec_t idx2vec(input midx_t idx);
    return mvec_t'(1) << idx;
  endfunction

  // index of the (single) set bit; zero when empty
  function automatic midx_t vec2idx(input mvec_t v);
    midx_t r;
    r = '0;
    for (int i = 0; i < NM; i++)
      if (v[i]) r = midx_t'(i);
    return r;
  endfunction

  // rotating search starting just past the last winner
  function automatic midx_t rr_pick(input mvec_t req, input midx_t last);
    midx_t w;
    logic  found;
    w = last;
    found = 1'b0;
    for (int k = 1; k <= NM; k++) begin
      int c;
      c = (int'(last) + k) % NM;
      if (!found && req[c]) begin
        w = midx_t'(c);
        found = 1'b1;
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/pbarb_straps.sv
`timescale 1ns/1ps
module pbarb_straps
  import pbarb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_in_n,
  input  logic [STRAP_W-1:0] strap_cfg,
  output logic [STRAP_W-1:0] strap_q,
  output logic               arb_en,
  output logic               central_en,
  output logic               bus_rst_o_n,
  output logic               bus_rst_oe
);
  logic [STRAP_W-1:0] cfg_q;
  logic               rst_out_q;

  // straps follow the pins while reset is held, then freeze
  always_ff @(posedge clk) begin
    if (!rst_in_n) cfg_q <= strap_cfg;
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) rst_out_q <= 1'b0;
    else           rst_out_q <= 1'b1;
  end

  assign strap_q     = cfg_q;
  assign arb_en      = cfg_q[STRAP_ARB];
  assign central_en  = cfg_q[STRAP_CEN];
  assign bus_rst_o_n = rst_out_q;
  assign bus_rst_oe  = cfg_q[STRAP_CEN];
endmodule

// File: rtl/pbarb_grant_core.sv
`timescale 1ns/1ps
module pbarb_grant_core
  import pbarb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_in_n,
  input  logic  arb_en,
  input  mvec_t req_vec,
  input  logic  bus_idle,
  output mvec_t grant_vec,
  output logic  release_ev,
  output logic  award_ev
);
  mvec_t gnt_q, gnt_d;
  midx_t last_q, last_d;
  midx_t owner, winner;
  logic  owner_req, others_req, any_req, park_ev;

  always_comb begin
    owner      = vec2idx(gnt_q);
    owner_req  = |(gnt_q & req_vec);
    others_req = |(req_vec & ~gnt_q);
    any_req    = |req_vec;
    winner     = rr_pick(req_vec, last_q);

    release_ev = (gnt_q != '0) &&
                 ((!owner_req && owner != IDX_INT) ||
                  (others_req && (bus_idle || !owner_req)));
    award_ev   = (gnt_q == '0) && any_req;
    park_ev    = (gnt_q == '0) && !any_req;

    gnt_d  = gnt_q;
    last_d = last_q;
    if (release_ev) begin
      gnt_d = '0;
    end else if (award_ev) begin
      gnt_d  = idx2vec(winner);
      last_d = winner;
    end else if (park_ev) begin
      gnt_d = idx2vec(IDX_INT);
    end
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      gnt_q  <= idx2vec(IDX_INT);
      last_q <= IDX_INT;
    end else if (arb_en) begin
      gnt_q  <= gnt_d;
      last_q <= last_d;
    end
  end

  assign grant_vec = gnt_q;
endmodule

// File: rtl/pbarb_err_mon.sv
`timescale 1ns/1ps
module pbarb_err_mon (
  input  logic clk,
  input  logic rst_in_n,
  input  logic central_en,
  input  logic sys_err_n,
  output logic err_flag
);
  logic err_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n)                     err_q <= 1'b0;
    else if (central_en && !sys_err_n) err_q <= 1'b1;
  end

  assign err_flag = err_q;
endmodule

// File: rtl/pbus_central_arb.sv
`timescale 1ns/1ps
module pbus_central_arb
  import pbarb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_in_n,
  input  logic [STRAP_W-1:0] strap_cfg,
  input  logic               int_req,
  output logic               int_gnt,
  output logic               park_drive,
  output logic               xarb_req_n,
  input  logic               xarb_gnt_n,
  input  logic [NUM_EXT-1:0] ext_req_n,
  output logic [NUM_EXT-1:0] ext_gnt_n,
  input  logic               bus_frame_n,
  input  logic               bus_irdy_n,
  output logic               bus_rst_o_n,
  output logic               bus_rst_oe,
  input  logic               sys_err_n,
  output logic               err_flag
);
  logic [STRAP_W-1:0] strap_q;
  logic  arb_en, central_en;
  mvec_t req_vec, grant_vec;
  logic  bus_idle, release_ev, award_ev;

  assign req_vec[IDX_INT] = int_req;
  assign bus_idle         = bus_frame_n & bus_irdy_n;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    assign req_vec[g+1]  = ~ext_req_n[g];
    assign ext_gnt_n[g]  = arb_en ? ~grant_vec[g+1] : 1'b1;
  end

  pbarb_straps u_straps (
    .clk         (clk),
    .rst_in_n    (rst_in_n),
    .strap_cfg   (strap_cfg),
    .strap_q     (strap_q),
    .arb_en      (arb_en),
    .central_en  (central_en),
    .bus_rst_o_n (bus_rst_o_n),
    .bus_rst_oe  (bus_rst_oe)
  );

  pbarb_grant_core u_core (
    .clk        (clk),
    .rst_in_n   (rst_in_n),
    .arb_en     (arb_en),
    .req_vec    (req_vec),
    .bus_idle   (bus_idle),
    .grant_vec  (grant_vec),
    .release_ev (release_ev),
    .award_ev   (award_ev)
  );

  pbarb_err_mon u_err (
    .clk        (clk),
    .rst_in_n   (rst_in_n),
    .central_en (central_en),
    .sys_err_n  (sys_err_n),
    .err_flag   (err_flag)
  );

  assign int_gnt    = arb_en ? grant_vec[IDX_INT] : ~xarb_gnt_n;
  assign xarb_req_n = arb_en ? 1'b1 : ~int_req;
  assign park_drive = arb_en && (!rst_in_n || (grant_vec[IDX_INT] && !int_req));
endmodule

// File: rtl/pbarb_checker.sv
`timescale 1ns/1ps
module pbarb_checker
  import pbarb_pkg::*;
(
  input logic               clk,
  input logic               rst_in_n,
  input logic [STRAP_W-1:0] strap_q,
  input logic               arb_en,
  input mvec_t              req_vec,
  input mvec_t              grant_vec,
  input logic               bus_idle,
  input logic               award_ev,
  input logic               release_ev,
  input logic               int_gnt,
  input logic [NUM_EXT-1:0] ext_gnt_n,
  input logic               err_flag
);
  logic up;
  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) up <= 1'b0;
    else           up <= 1'b1;
  end

  assert_straps_frozen_R1: assert property (@(posedge clk) disable iff (!rst_in_n)
    up |-> $stable(strap_q));

  assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_in_n)
    arb_en |-> $onehot0({~ext_gnt_n, int_gnt}));

  assert_idle_gap_R4: assert property (@(posedge clk) disable iff (!rst_in_n)
    (up && arb_en && grant_vec != '0 && $past(grant_vec) != '0) |-> grant_vec == $past(grant_vec));

  assert_no_empty_run_R4: assert property (@(posedge clk) disable iff (!rst_in_n)
    (up && arb_en && $past(grant_vec) == '0) |-> grant_vec != '0);

  assert_award_single_R5: assert property (@(posedge clk) disable iff (!rst_in_n)
    (arb_en && award_ev) |=> $countones(grant_vec) == 1);

  assert_hold_busy_R6: assert property (@(posedge clk) disable iff (!rst_in_n)
    (up && arb_en && ($past(grant_vec) & $past(req_vec)) != '0 && !$past(bus_idle))
      |-> grant_vec == $past(grant_vec));

  assert_release_empty_R6: assert property (@(posedge clk) disable iff (!rst_in_n)
    (arb_en && release_ev) |=> grant_vec == '0);

  assert_park_R7: assert property (@(posedge clk) disable iff (!rst_in_n)
    (up && arb_en && $past(grant_vec) == '0 && $past(req_vec) == '0) |-> grant_vec == idx2vec(IDX_INT));

  assert_off_no_ext_R8: assert property (@(posedge clk) disable iff (!rst_in_n)
    !arb_en |-> ext_gnt_n == '1);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_in_n)
    (up && $past(err_flag)) |-> err_flag);
endmodule

bind pbus_central_arb pbarb_checker u_chk (
  .clk        (clk),
  .rst_in_n   (rst_in_n),
  .strap_q    (strap_q),
  .arb_en     (arb_en),
  .req_vec    (req_vec),
  .grant_vec  (grant_vec),
  .bus_idle   (bus_idle),
  .award_ev   (award_ev),
  .release_ev (release_ev),
  .int_gnt    (int_gnt),
  .ext_gnt_n  (ext_gnt_n),
  .err_flag   (err_flag)
);

// File: tb/tb_pbus_central_arb.sv
`timescale 1ns/1ps
module tb_pbus_central_arb;
  logic       clk = 1'b0;
  logic       rst_in_n = 1'b0;
  logic [1:0] strap_cfg = 2'b11;
  logic       int_req = 1'b0;
  logic       int_gnt, park_drive, xarb_req_n;
  logic       xarb_gnt_n = 1'b1;
  logic [1:0] ext_req_n = 2'b11;
  logic [1:0] ext_gnt_n;
  logic       bus_frame_n = 1'b1, bus_irdy_n = 1'b1;
  logic       bus_rst_o_n, bus_rst_oe;
  logic       sys_err_n = 1'b1;
  logic       err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_own;   // -1 no grant, 0 internal, 1/2 external
  int m_last;

  always #2.5 clk = ~clk;

  pbus_central_arb dut (
    .clk(clk), .rst_in_n(rst_in_n), .strap_cfg(strap_cfg),
    .int_req(int_req), .int_gnt(int_gnt), .park_drive(park_drive),
    .xarb_req_n(xarb_req_n), .xarb_gnt_n(xarb_gnt_n),
    .ext_req_n(ext_req_n), .ext_gnt_n(ext_gnt_n),
    .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n),
    .bus_rst_o_n(bus_rst_o_n), .bus_rst_oe(bus_rst_oe),
    .sys_err_n(sys_err_n), .err_flag(err_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int gvec();
    return int'({~ext_gnt_n, int_gnt});
  endfunction

  function automatic int own2vec(input int o);
    return (o < 0) ? 0 : (1 << o);
  endfunction

  // reference: next owner from the requirement text (R4 R5 R6 R7)
  task automatic model_next();
    logic [2:0] r;
    bit idle, oreq, oth;
    r = {~ext_req_n, int_req};
    idle = bus_frame_n && bus_irdy_n;
    if (m_own < 0) begin
      if (r != 3'b000) begin
        for (int k = 1; k <= 3; k++) begin
          int c;
          c = (m_last + k) % 3;
          if (r[c]) begin
            m_own = c;
            m_last = c;
            break;
          end
        end
      end else begin
        m_own = 0;
      end
    end else begin
      oreq = r[m_own];
      oth  = (r & ~(3'b001 << m_own)) != 3'b000;
      if ((m_own != 0 && !oreq) || (oth && (idle || !oreq))) m_own = -1;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic step_model(input string req);
    model_next();
    tick();
    chk(req, gvec(), own2vec(m_own));
    chk("R7 park_drive", int'(park_drive), int'(m_own == 0 && !int_req));
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst_in_n = 1'b0;
    strap_cfg = s;
    int_req = 1'b0; ext_req_n = 2'b11; bus_frame_n = 1'b1; bus_irdy_n = 1'b1;
    sys_err_n = 1'b1; xarb_gnt_n = 1'b1;
    tick(); tick(); tick();
    rst_in_n = 1'b1;
    m_own = 0;
    m_last = 0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [2:0] rr_exp [8];
    rr_exp = '{3'b000, 3'b010, 3'b000, 3'b100, 3'b000, 3'b001, 3'b000, 3'b010};

    // ---- reset state, R2 R9
    rst_in_n = 1'b0;
    strap_cfg = 2'b11;
    tick(); tick(); tick();
    chk("R2 int_gnt in reset", int'(int_gnt), 1);
    chk("R2 ext_gnt_n in reset", int'(ext_gnt_n), 3);
    chk("R2 park_drive in reset", int'(park_drive), 1);
    chk("R9 bus_rst_o_n in reset", int'(bus_rst_o_n), 0);
    chk("R9 bus_rst_oe central", int'(bus_rst_oe), 1);
    chk("R8 xarb_req_n enabled", int'(xarb_req_n), 1);
    chk("R10 err_flag in reset", int'(err_flag), 0);
    rst_in_n = 1'b1;
    m_own = 0; m_last = 0;
    #0.5;
    chk("R9 bus_rst_o_n before edge", int'(bus_rst_o_n), 0);

    // ---- R1: pins change after release; arbiter stays on. R5 rotation.
    strap_cfg = 2'b00;
    int_req = 1'b1; ext_req_n = 2'b00;
    for (int k = 0; k < 8; k++) begin
      model_next();
      tick();
      if (k == 0) chk("R9 bus_rst_o_n after edge", int'(bus_rst_o_n), 1);
      chk("R5 R4 round robin order", gvec(), int'(rr_exp[k]));
      chk("R5 model agree", gvec(), own2vec(m_own));
    end
    chk("R1 central strap frozen", int'(bus_rst_oe), 1);

    // ---- R6 hold while busy, release on drop, R7 park
    do_reset(2'b11);
    ext_req_n = 2'b10;                    // only ext0
    step_model("R6 parked owner yields");  // -> none
    step_model("R5 ext0 awarded");         // -> ext0
    chk("R5 ext0 grant", int'(ext_gnt_n), 2);
    bus_frame_n = 1'b0; ext_req_n = 2'b00; int_req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step_model("R6 hold while busy");
      chk("R6 ext0 kept", int'(ext_gnt_n), 2);
    end
    ext_req_n = 2'b01;                     // ext0 drops, ext1 asks
    step_model("R6 release on drop");
    chk("R4 gap after release", gvec(), 0);
    step_model("R5 ext1 after ext0");
    chk("R5 ext1 grant", int'(ext_gnt_n), 1);
    bus_frame_n = 1'b1; ext_req_n = 2'b11; int_req = 1'b0;
    step_model("R6 ext1 dropped");
    step_model("R7 park after idle");
    chk("R7 parked internal", int'(int_gnt), 1);
    chk("R7 park_drive", int'(park_drive), 1);

    // ---- near-exhaustive sweep against the reference
    do_reset(2'b11);
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] p;
      p = 5'($urandom);
      if (n % 3 != 0) begin
        int_req = p[0]; ext_req_n = p[2:1];
        bus_frame_n = p[3]; bus_irdy_n = p[4] | p[3];
      end
      step_model("R3 R4 R5 R6 sweep");
    end

    // ---- R10 sticky error in central mode
    do_reset(2'b11);
    tick();
    chk("R10 flag clear", int'(err_flag), 0);
    sys_err_n = 1'b0;
    tick();
    chk("R10 flag set", int'(err_flag), 1);
    sys_err_n = 1'b1;
    tick(); tick(); tick();
    chk("R10 flag sticky", int'(err_flag), 1);
    do_reset(2'b11);
    chk("R10 cleared by reset", int'(err_flag), 0);

    // ---- R8 arbiter off, R10 ignored without central, R9 oe off
    do_reset(2'b00);
    chk("R9 bus_rst_oe off", int'(bus_rst_oe), 0);
    for (int v = 0; v < 32; v++) begin
      logic [4:0] p;
      p = 5'(v);
      int_req = p[0]; ext_req_n = p[2:1]; xarb_gnt_n = p[3]; sys_err_n = p[4];
      #1;
      chk("R8 ext grants off", int'(ext_gnt_n), 3);
      chk("R8 int_gnt from outside", int'(int_gnt), int'(!p[3]));
      chk("R8 request passed out", int'(xarb_req_n), int'(!p[0]));
      chk("R8 no park drive", int'(park_drive), 0);
      tick();
      chk("R10 ignored when central off", int'(err_flag), 0);
    end

    // ---- R1 arbiter strap only, then pins flip after release
    do_reset(2'b01);
    strap_cfg = 2'b10;
    sys_err_n = 1'b0;
    tick();
    chk("R1 central stays off", int'(bus_rst_oe), 0);
    chk("R1 R10 error ignored", int'(err_flag), 0);
    chk("R1 arbiter stays on", int'(xarb_req_n), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule